// File: doc/BRIEF.md
# Crossing-Number Alignment Unit

This unit lines up one trigger data stream with the global orbit. After a start pulse it clears an occupancy histogram that has one bin for each crossing position in the orbit. It then waits for the broadcast orbit marker from the timing system and counts valid, nonzero trigger words per crossing over a chosen number of orbits. The filled and empty pattern of the beam shows up in the bins.

When accumulation ends, the unit scans the histogram once around the orbit and a second time to cover the wrap-around. It finds the longest run of empty bins. The crossing just after that run is taken as the orbit start seen in the data. The distance from that crossing forward to the broadcast marker, taken modulo the orbit length, becomes the delay applied to the stream. Channels that use the same broadcast marker therefore emit words from the same crossing on the same cycle.

The data path has a fixed base latency plus the selected delay. It keeps streaming the whole time. A measured delay beyond the supported maximum raises an error flag instead of locking. A histogram with no structure also raises the error flag.

Top module: `bx_aligner`

## Requirements
- R1: The input sample that arrives with `bc0_i` high is crossing 0. Each later sample is one crossing further on, and the count wraps to 0 after crossing ORBIT_LEN-1.
- R2: A `start_i` pulse clears every histogram bin and restarts the measurement, even while a measurement is running. On the cycle after the pulse, `locked_o` and `error_o` are low, and they stay low until a new result is ready.
- R3: A bin is incremented only for a sample with `tp_valid_i` high and `tp_data_i` nonzero. Invalid words and zero words leave the histogram unchanged.
- R4: Each bin saturates at 2^CNT_W-1 and never wraps back to zero.
- R5: Accumulation starts at the first broadcast marker after the clear and lasts `n_orbits_i` full orbits, where a value of 0 means one orbit. The data marker is the crossing that follows the longest circular run of empty bins. This assumes one run is strictly longest.
- R6: The offset is (ORBIT_LEN - marker) mod ORBIT_LEN. When the offset is at most MAX_DLY, `offset_o` takes that value and `locked_o` rises with `error_o` low. `offset_o` stays constant while locked.
- R7: If the offset exceeds MAX_DLY, `error_o` goes high, `locked_o` stays low and `offset_o` is set to MAX_DLY.
- R8: A histogram with no empty bin, or with no filled bin, gives the same result as R7.
- R9: After reset, `offset_o` is 0 and both flags are low. At all times, `{valid_o, data_o}` in cycle c equals `{tp_valid_i, tp_data_i}` of cycle c-(BASE_LAT+d), where d is the value `offset_o` had in cycle c-1.
- R10: A result (locked or error) appears no later than (orbits+4)*ORBIT_LEN+8 cycles after the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Clears the histogram and begins a measurement |
| n_orbits_i | input | ORB_W | Number of orbits to accumulate (0 means 1), sampled at start |
| bc0_i | input | 1 | Broadcast orbit marker; marks crossing 0 |
| tp_valid_i | input | 1 | Trigger word valid |
| tp_data_i | input | DATA_W | Trigger word |
| data_o | output | DATA_W | Delayed trigger word |
| valid_o | output | 1 | Delayed valid |
| offset_o | output | OFF_W | Applied delay in crossings |
| locked_o | output | 1 | Measured offset is applied |
| error_o | output | 1 | Offset out of range or no beam structure found |

## Verification
The stimulus uses single contiguous bunch trains placed at different points in the orbit. This separates an offset of zero, a mid-range offset, the exact MAX_DLY boundary and one crossing past it. A train broken by single-crossing holes, with invalid nonzero words and valid zero words placed in the gap, checks that only valid nonzero words count and that the scan picks the longest gap rather than the first one. Empty and fully filled orbits exercise the no-structure error. Back-to-back measurements, and a restart while accumulation is running, are arranged so that any leftover counts would move the marker. A small bin width with more orbits than the counter can hold checks saturation, because wrapping would make the filled bins look empty.

// File: rtl/bxa_pkg.sv
package bxa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLEAR  = 3'd1,
        ST_SYNC   = 3'd2,
        ST_ACCUM  = 3'd3,
        ST_SCAN   = 3'd4,
        ST_DRAIN  = 3'd5,
        ST_RESULT = 3'd6
    } bxa_state_e;
endpackage

// File: rtl/bxa_bx_counter.sv
module bxa_bx_counter #(
    parameter int ORBIT_LEN = 3564,
    localparam int BX_W = (ORBIT_LEN > 1) ? $clog2(ORBIT_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bc0_i,
    output logic [BX_W-1:0] cur_bx_o
);
    localparam logic [BX_W-1:0] LAST_BX = BX_W'(ORBIT_LEN - 1);

    logic [BX_W-1:0] bx_d, bx_q;

    always_comb begin
        cur_bx_o = bc0_i ? '0 : bx_q;
        bx_d     = (cur_bx_o == LAST_BX) ? '0 : cur_bx_o + BX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bx_q <= '0;
        else        bx_q <= bx_d;
    end

    generate
        if (ORBIT_LEN > 1) begin : g_chk
            // R1
            bc0_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bc0_i |=> (bx_q == BX_W'(1)));
            // R1
            orbit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!bc0_i && bx_q == LAST_BX) |=> (bx_q == '0));
        end
    endgenerate
endmodule

// File: rtl/bxa_hist_ram.sv
module bxa_hist_ram #(
    parameter int DEPTH = 3564,
    parameter int AW    = 12,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/bxa_delay_line.sv
module bxa_delay_line #(
    parameter int W        = 9,
    parameter int BASE_LAT = 3,
    parameter int MAX_DLY  = 15,
    localparam int SEL_W   = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     in_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     out_o
);
    localparam int LEN  = BASE_LAT - 1 + MAX_DLY;
    localparam int IDXW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [W-1:0]    sr_d [LEN];
    logic [W-1:0]    sr_q [LEN];
    logic [W-1:0]    out_d, out_q;
    logic [IDXW-1:0] tap;

    always_comb begin
        sr_d[0] = in_i;
        for (int i = 1; i < LEN; i++) sr_d[i] = sr_q[i-1];
        tap   = IDXW'(BASE_LAT - 2) + IDXW'(sel_i);
        out_d = sr_q[tap];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LEN; i++) sr_q[i] <= '0;
            out_q <= '0;
        end else begin
            sr_q  <= sr_d;
            out_q <= out_d;
        end
    end

    assign out_o = out_q;
endmodule

// File: rtl/bx_aligner.sv
module bx_aligner
    import bxa_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = 16,
    parameter int ORB_W     = 8,
    parameter int MAX_DLY   = 15,
    parameter int BASE_LAT  = 3,
    localparam int OFF_W    = $clog2(MAX_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ORB_W-1:0]  n_orbits_i,
    input  logic              bc0_i,
    input  logic              tp_valid_i,
    input  logic [DATA_W-1:0] tp_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic              locked_o,
    output logic              error_o
);
    localparam int BX_W   = (ORBIT_LEN > 1) ? $clog2(ORBIT_LEN) : 1;
    localparam int SCAN_W = $clog2(2 * ORBIT_LEN);
    localparam int RUN_W  = $clog2(2 * ORBIT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [BX_W-1:0]  LAST_BX = BX_W'(ORBIT_LEN - 1);

    typedef struct packed {
        bxa_state_e       state;
        logic [BX_W-1:0]  clr_addr;
        logic [ORB_W-1:0] orb_cnt;
        logic [ORB_W-1:0] orb_tgt;
        logic             p_valid;
        logic [BX_W-1:0]  p_addr;
        logic             p_inc;
        logic [SCAN_W-1:0] scan;
        logic             s_valid;
        logic [BX_W-1:0]  s_addr;
        logic [RUN_W-1:0] run;
        logic [RUN_W-1:0] best;
        logic [BX_W-1:0]  mark;
        logic [OFF_W-1:0] dly;
        logic             locked;
        logic             error;
    } regs_t;

    regs_t r_d, r_q;

    logic [BX_W-1:0]   cur_bx;
    logic              ram_we;
    logic [BX_W-1:0]   ram_waddr, ram_raddr, scan_addr, off_raw;
    logic [CNT_W-1:0]  ram_wdata, ram_rdata;
    logic              take;

    bxa_bx_counter #(.ORBIT_LEN(ORBIT_LEN)) u_bx (
        .clk(clk), .rst_n(rst_n), .bc0_i(bc0_i), .cur_bx_o(cur_bx)
    );

    bxa_hist_ram #(.DEPTH(ORBIT_LEN), .AW(BX_W), .DW(CNT_W)) u_ram (
        .clk(clk), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
        .raddr_i(ram_raddr), .rdata_o(ram_rdata)
    );

    bxa_delay_line #(.W(DATA_W + 1), .BASE_LAT(BASE_LAT), .MAX_DLY(MAX_DLY)) u_dly (
        .clk(clk), .rst_n(rst_n), .in_i({tp_valid_i, tp_data_i}),
        .sel_i(r_q.dly), .out_o({valid_o, data_o})
    );

    always_comb begin
        r_d       = r_q;
        r_d.p_valid = 1'b0;
        r_d.s_valid = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = r_q.p_addr;
        ram_wdata = ram_rdata;
        ram_raddr = cur_bx;
        scan_addr = (r_q.scan >= SCAN_W'(ORBIT_LEN)) ? BX_W'(r_q.scan - SCAN_W'(ORBIT_LEN))
                                                     : BX_W'(r_q.scan);
        off_raw   = (r_q.mark == '0) ? '0 : BX_W'(ORBIT_LEN) - r_q.mark;
        take      = (r_q.state == ST_ACCUM) || (r_q.state == ST_SYNC && bc0_i);

        // second half of the read-modify-write on a histogram bin
        if (r_q.p_valid) begin
            ram_we    = 1'b1;
            ram_wdata = (r_q.p_inc && ram_rdata != CNT_MAX) ? ram_rdata + CNT_W'(1) : ram_rdata;
        end

        // gap tracking on the bin read in the previous scan cycle
        if (r_q.s_valid) begin
            if (ram_rdata == '0) begin
                r_d.run = r_q.run + RUN_W'(1);
            end else begin
                if (r_q.run > r_q.best) begin
                    r_d.best = r_q.run;
                    r_d.mark = r_q.s_addr;
                end
                r_d.run = '0;
            end
        end

        if (take) begin
            ram_raddr = cur_bx;
            r_d.p_valid = 1'b1;
            r_d.p_addr  = cur_bx;
            r_d.p_inc   = tp_valid_i && (tp_data_i != '0);
            r_d.state   = ST_ACCUM;
            if (cur_bx == LAST_BX) begin
                if (ORB_W'(r_q.orb_cnt + ORB_W'(1)) >= r_q.orb_tgt) begin
                    r_d.state = ST_SCAN;
                    r_d.scan  = '0;
                    r_d.run   = '0;
                    r_d.best  = '0;
                    r_d.mark  = '0;
                end else begin
                    r_d.orb_cnt = r_q.orb_cnt + ORB_W'(1);
                end
            end
        end

        unique case (r_q.state)
            ST_CLEAR: begin
                ram_we       = 1'b1;
                ram_waddr    = r_q.clr_addr;
                ram_wdata    = '0;
                r_d.clr_addr = r_q.clr_addr + BX_W'(1);
                if (r_q.clr_addr == LAST_BX) r_d.state = ST_SYNC;
            end
            ST_SCAN: begin
                ram_raddr   = scan_addr;
                r_d.s_valid = 1'b1;
                r_d.s_addr  = scan_addr;
                r_d.scan    = r_q.scan + SCAN_W'(1);
                if (r_q.scan == SCAN_W'(2 * ORBIT_LEN - 1)) r_d.state = ST_DRAIN;
            end
            ST_DRAIN: r_d.state = ST_RESULT;
            ST_RESULT: begin
                r_d.state = ST_IDLE;
                if (r_q.best == '0 || off_raw > BX_W'(MAX_DLY)) begin
                    r_d.error = 1'b1;
                    r_d.dly   = OFF_W'(MAX_DLY);
                end else begin
                    r_d.locked = 1'b1;
                    r_d.dly    = OFF_W'(off_raw);
                end
            end
            default: ;
        endcase

        if (start_i) begin
            r_d.state    = ST_CLEAR;
            r_d.clr_addr = '0;
            r_d.orb_cnt  = '0;
            r_d.orb_tgt  = (n_orbits_i == '0) ? ORB_W'(1) : n_orbits_i;
            r_d.p_valid  = 1'b0;
            r_d.s_valid  = 1'b0;
            r_d.locked   = 1'b0;
            r_d.error    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign offset_o = r_q.dly;
    assign locked_o = r_q.locked;
    assign error_o  = r_q.error;

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!locked_o && !error_o));
    // R7
    error_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (!locked_o && offset_o == OFF_W'(MAX_DLY)));
    // R6
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> $stable(offset_o));
endmodule

// File: tb/sim_bx_aligner.sv
module sim_bx_aligner;
    localparam int L      = 40;
    localparam int DW     = 8;
    localparam int CW     = 2;
    localparam int MAXD   = 15;
    localparam int BASE   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    n_orbits_i = '0;
    logic          bc0_i = 1'b0;
    logic          tp_valid_i = 1'b0;
    logic [DW-1:0] tp_data_i = '0;
    logic [DW-1:0] data_o;
    logic          valid_o;
    logic [3:0]    offset_o;
    logic          locked_o;
    logic          error_o;

    int n_chk = 0;
    int n_fail = 0;

    bit pat_on = 0;
    int pat_m = 0, pat_len = 0;
    bit pat_hole = 0, pat_noise = 0;

    logic [DW:0] hbuf [64];
    int cyc = 64;
    int gx = 0;
    int prev_off = 0;

    always #4 clk = ~clk;

    bx_aligner #(.DATA_W(DW), .ORBIT_LEN(L), .CNT_W(CW), .ORB_W(8),
                 .MAX_DLY(MAXD), .BASE_LAT(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_orbits_i(n_orbits_i),
        .bc0_i(bc0_i), .tp_valid_i(tp_valid_i), .tp_data_i(tp_data_i),
        .data_o(data_o), .valid_o(valid_o), .offset_o(offset_o),
        .locked_o(locked_o), .error_o(error_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit filled_at(input int x);
        int rel;
        if (!pat_on) return 1'b0;
        rel = (x - pat_m + L) % L;
        return (rel < pat_len) && !(pat_hole && (rel % 5 == 4));
    endfunction

    // expected result from the stimulus pattern: longest circular empty run
    task automatic ref_result(output int off, output bit err);
        bit f [L];
        int best, mk, r;
        best = 0; mk = 0;
        for (int x = 0; x < L; x++) f[x] = filled_at(x);
        for (int s = 0; s < L; s++) begin
            if (f[s] && !f[(s + L - 1) % L]) begin
                r = 0;
                while (r < L && !f[(s - 1 - r + 2 * L) % L]) r++;
                if (r > best) begin best = r; mk = s; end
            end
        end
        off = (L - mk) % L;
        err = (best == 0) || (off > MAXD);
        if (err) off = MAXD;
    endtask

    // stimulus and per-cycle data path model
    initial begin
        for (int i = 0; i < 64; i++) hbuf[i] = '0;
        forever begin
            @(negedge clk); #1;
            if (!rst_n) begin
                bc0_i = 0; tp_valid_i = 0; tp_data_i = '0;
            end else begin
                // R9: delayed stream follows base latency plus applied offset
                chk({valid_o, data_o} == hbuf[(cyc - BASE - prev_off) % 64], "R9",
                    int'({valid_o, data_o}), int'(hbuf[(cyc - BASE - prev_off) % 64]));
                bc0_i = (gx == 0);
                if (filled_at(gx)) begin
                    tp_valid_i = 1; tp_data_i = DW'((gx * 7) | 1);
                end else if (pat_noise) begin
                    if (((gx - pat_m + L) % L) % 2 == 1) begin
                        tp_valid_i = 0; tp_data_i = 8'hA5;
                    end else begin
                        tp_valid_i = 1; tp_data_i = '0;
                    end
                end else begin
                    tp_valid_i = 0; tp_data_i = '0;
                end
                hbuf[cyc % 64] = {tp_valid_i, tp_data_i};
                prev_off = int'(offset_o);
                cyc++;
                gx = (gx + 1) % L;
            end
        end
    end

    task automatic set_pat(input bit on, input int m, input int len, input bit hole, input bit noise);
        @(negedge clk);
        pat_on = on; pat_m = m; pat_len = len; pat_hole = hole; pat_noise = noise;
        @(negedge clk);
    endtask

    task automatic measure(input int orbits, input string tag);
        int waited, eff, exp_off;
        bit exp_err;
        ref_result(exp_off, exp_err);
        eff = (orbits == 0) ? 1 : orbits;
        start_i = 1; n_orbits_i = 8'(orbits);
        @(negedge clk);
        start_i = 0;
        // R2: flags drop right after start
        chk(!locked_o && !error_o, {tag, " R2 flags low after start"},
            int'({locked_o, error_o}), 0);
        waited = 1;
        while (!(locked_o || error_o) && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        // R10: result within bound
        chk(waited <= (eff + 4) * L + 8, {tag, " R10 result time"}, waited, (eff + 4) * L + 8);
        chk(error_o == exp_err, {tag, " R7/R8 error flag"}, int'(error_o), int'(exp_err));
        chk(locked_o == !exp_err, {tag, " R6 locked flag"}, int'(locked_o), int'(!exp_err));
        chk(int'(offset_o) == exp_off, {tag, " R5/R6 offset"}, int'(offset_o), exp_off);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        chk(offset_o == 0, "R9 reset offset", int'(offset_o), 0);
        chk(!locked_o && !error_o, "R9 reset flags", int'({locked_o, error_o}), 0);
        chk(!valid_o, "R9 reset valid", int'(valid_o), 0);

        // R1 R4 R5 R6: train at 30, offset 10; 4 orbits saturate 2-bit bins
        set_pat(1, 30, 20, 0, 0);
        measure(4, "T1");
        chk(offset_o == 10, "R4 saturated bins keep marker", int'(offset_o), 10);
        // R2: second run must not see old bins (stale counts would give 10)
        set_pat(1, 0, 15, 0, 0);
        measure(2, "T2");
        // R5 R6: n_orbits 0 acts as one orbit; offset exactly MAX
        set_pat(1, 25, 10, 0, 0);
        measure(0, "T3");
        // R7: offset one past MAX
        set_pat(1, 24, 10, 0, 0);
        measure(1, "T4");
        chk(offset_o == MAXD, "R7 clamp", int'(offset_o), MAXD);
        // R3 R5: holes in train, invalid nonzero and valid zero in the gap
        set_pat(1, 35, 25, 1, 1);
        measure(3, "T5");
        chk(offset_o == 5, "R3 noise ignored", int'(offset_o), 5);
        // R8: empty histogram
        set_pat(0, 0, 0, 0, 0);
        measure(1, "T6");
        // R8: every bin filled
        set_pat(1, 0, L, 0, 0);
        measure(1, "T7");
        chk(error_o, "R8 full orbit error", int'(error_o), 1);
        // R2: restart during accumulation; stale short train would give 15
        set_pat(1, 25, 3, 0, 0);
        start_i = 1; n_orbits_i = 8'd4;
        @(negedge clk);
        start_i = 0;
        repeat (130) @(negedge clk);
        set_pat(1, 30, 12, 0, 0);
        measure(2, "T8");
        chk(offset_o == 10, "R2 restart clears", int'(offset_o), 10);

        repeat (40) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule